// File: doc/BRIEF.md
# Frame Buffer Fetch Sequencer

This block feeds a display raster engine with pixel words read from memory. Software programs a start address and an inclusive end address as one 64-bit register write. It also programs a control word that chooses the burst length, the FIFO refill level and the fetch kind. When the raster enable input rises, the sequencer takes a private copy of these settings. It then issues burst read requests that walk upward from the start address until the last word at or below the end address has been read.

There are two fetch kinds. In frame mode the returned words are queued in a pixel FIFO, which the raster engine drains with a valid/ready handshake. At the end of each frame a one-cycle end-of-frame pulse is raised, and the walk begins again from a freshly copied start address for as long as raster enable stays high. In palette mode exactly 32 bytes are read from the start address and delivered on a separate indexed palette write port. A palette-loaded pulse then follows. For true-colour use, the palette region in memory is expected to hold 0x4000 in its first 16-bit entry and zero in every other entry; the block moves those words unchanged.

A one-cycle underflow pulse reports each cycle in which the raster engine asks for a pixel that the FIFO cannot supply.

Top module: `scanfetch_top`

## Requirements
- R1: While reset is held and on the first cycle after it, mem_req, px_valid, pal_we, pal_done, eof and underflow are all low.
- R2: A control write (cfg_sel=0) uses these fields. Bits [2:0] hold the burst code: 0..4 select 1, 2, 4, 8 or 16 words, and 5..7 also select 16. Bit 4 selects palette mode when 1 and frame mode when 0. Bits [12:8] hold the refill threshold in words. Bit 3, a second-buffer request, has no effect on addresses or end-of-frame pulses.
- R3: An address write (cfg_sel=1) stores the start address from bits [31:0] and the inclusive end address from bits [63:32] in one cycle. The fetch uses a copy taken only at frame start, so a write made during a frame first affects the next frame.
- R4: Frame mode reads the words at start, start+4, start+8 and so on, up to the last word whose address is at or below the end address. The words enter the FIFO in address order. Each request is for the smaller of the burst length and the number of words left.
- R5: In frame mode a new burst is requested only when FIFO occupancy is at or below the threshold and the free space is at least the request length.
- R6: Palette mode reads exactly 8 words (32 bytes) from the start address and ignores the end address. It writes them to the palette port with indices 0 to 7 in order, and none of them enter the FIFO. It then pulses pal_done for one cycle and makes no further request until raster enable falls and rises again.
- R7: eof pulses once when the last word of a frame arrives. While raster_en stays high, the next frame restarts at the newly copied start address.
- R8: With raster_en low no request is made, but every beat of a burst already granted is still accepted. Once the sequencer is idle with raster_en low, the FIFO is emptied.
- R9: underflow pulses in a cycle after one in which raster_en is high, frame mode is running, px_ready is high and px_valid is low. It stays low while raster_en is low.
- R10: A request not yet acknowledged keeps mem_req high and mem_addr unchanged while raster_en stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = address pair |
| cfg_wdata | input | 64 | Register write data |
| raster_en | input | 1 | Raster enable |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Byte address of the first word of the burst |
| mem_len | output | 5 | Burst length in words |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_dvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data beat |
| px_valid | output | 1 | FIFO holds a pixel word |
| px_data | output | 32 | FIFO head word |
| px_ready | input | 1 | Raster engine takes the head word |
| pal_we | output | 1 | Palette word write strobe |
| pal_idx | output | 3 | Palette word index |
| pal_data | output | 32 | Palette word |
| pal_done | output | 1 | Palette loaded pulse |
| eof | output | 1 | End-of-frame pulse |
| underflow | output | 1 | FIFO underflow pulse |

## Verification
The bench builds the block with its default 32-word FIFO. That depth can hold two full 16-word bursts, so the refill rule can be observed at two thresholds, where a stalled raster yields 8 and then 12 fetched words with 4-word bursts. The default 16-word maximum burst brings two more cases within reach: a 70-word frame whose final request is cut to 6 words, and a burst code above 4 that clamps to 16. The palette region sits inside the bench memory with the true-colour pattern, and one palette run adds acknowledge delays so that request holding can be observed.

// File: rtl/scanfetch_pkg.sv
package scanfetch_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int WORD_SHIFT = $clog2(WORD_BYTES);
    localparam int MAX_BURST  = 16;
    localparam int LOG_BURST  = $clog2(MAX_BURST);
    localparam int LEN_W      = LOG_BURST + 1;
    localparam int CODE_W     = 3;
    localparam int PALSEL_BIT = 4;
    localparam int THR_LSB    = 8;
    localparam int THR_W      = 5;
    localparam int PAL_BYTES  = 32;
    localparam int PAL_WORDS  = PAL_BYTES / WORD_BYTES;
    localparam int PAL_IDX_W  = $clog2(PAL_WORDS);
    localparam int CFG_W      = 2 * ADDR_W;

    // Address pair as written in one access: end address in the upper half.
    typedef struct packed {
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] first;
    } span_t;

    typedef struct packed {
        logic [THR_W-1:0]  thr;
        logic              pal_only;
        logic [CODE_W-1:0] bcode;
    } fetch_cfg_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ASK   = 2'd1,
        SQ_BEATS = 2'd2,
        SQ_PALOK = 2'd3
    } seq_state_t;

    function automatic logic [LEN_W-1:0] burst_words(input logic [CODE_W-1:0] code);
        if (int'(code) >= LOG_BURST)
            return LEN_W'(MAX_BURST);
        return LEN_W'(1) << code;
    endfunction

    function automatic fetch_cfg_t unpack_ctrl(input logic [CFG_W-1:0] w);
        fetch_cfg_t f;
        f.bcode    = w[CODE_W-1:0];
        f.pal_only = w[PALSEL_BIT];
        f.thr      = w[THR_LSB +: THR_W];
        return f;
    endfunction

endpackage

// File: rtl/scanfetch_regs.sv
module scanfetch_regs
    import scanfetch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output span_t            sh_span,
    output fetch_cfg_t       sh_cfg
);

    // Both halves of the pair land on the same edge, so no reader ever
    // sees one new half next to one old half.
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_span <= '0;
            sh_cfg  <= '0;
        end else if (cfg_we) begin
            if (cfg_sel)
                sh_span <= span_t'(cfg_wdata);
            else
                sh_cfg <= unpack_ctrl(cfg_wdata);
        end
    end

endmodule

// File: rtl/scanfetch_fifo.sv
module scanfetch_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic                         valid,
    output logic [$clog2(DEPTH):0]       count
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign rdata = store[rd_ptr];
    assign valid = (count != '0);

    always_ff @(posedge clk) begin
        if (push)
            store[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)
                rd_ptr <= rd_ptr + PTR_W'(1);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CNT_W'(DEPTH)));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

endmodule

// File: rtl/scanfetch_seq.sv
module scanfetch_seq
    import scanfetch_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 raster_en,
    input  span_t                sh_span,
    input  fetch_cfg_t           sh_cfg,
    input  logic [CNT_W-1:0]     fifo_count,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [LEN_W-1:0]     mem_len,
    input  logic                 mem_ack,
    input  logic                 mem_dvalid,
    output logic                 fifo_push,
    output logic                 fifo_flush,
    output logic                 pal_we,
    output logic [PAL_IDX_W-1:0] pal_idx,
    output logic                 pal_done,
    output logic                 eof,
    output logic                 data_active
);

    seq_state_t        state;
    logic [ADDR_W-1:0] cur_first;
    logic [ADDR_W-1:0] cur_last;
    logic [ADDR_W-1:0] addr;
    fetch_cfg_t        cfg_l;
    logic [LEN_W-1:0]  beats_left;
    logic              final_burst;
    logic [PAL_IDX_W-1:0] pal_cnt;

    logic [ADDR_W-1:0] words_left;
    logic [LEN_W-1:0]  bw;
    logic [LEN_W-1:0]  blen;
    logic [CNT_W-1:0]  free_slots;
    logic              room_ok;
    logic              beat;
    logic              last_beat;

    always_comb begin
        words_left = ((cur_last - addr) >> WORD_SHIFT) + ADDR_W'(1);
        bw         = burst_words(cfg_l.bcode);
        blen       = (words_left < ADDR_W'(bw)) ? LEN_W'(words_left) : bw;
        free_slots = CNT_W'(FIFO_DEPTH) - fifo_count;
        room_ok    = cfg_l.pal_only ||
                     ((fifo_count <= CNT_W'(cfg_l.thr)) && (free_slots >= CNT_W'(blen)));
        mem_req    = (state == SQ_ASK) && raster_en && room_ok;
        mem_addr   = addr;
        mem_len    = blen;
        beat       = (state == SQ_BEATS) && mem_dvalid;
        last_beat  = beat && (beats_left == LEN_W'(1));
        fifo_push  = beat && !cfg_l.pal_only;
        pal_we     = beat && cfg_l.pal_only;
        pal_idx    = pal_cnt;
        fifo_flush = (state == SQ_IDLE) && !raster_en;
        data_active = !cfg_l.pal_only && (state == SQ_ASK || state == SQ_BEATS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_IDLE;
            cur_first   <= '0;
            cur_last    <= '0;
            addr        <= '0;
            cfg_l       <= '0;
            beats_left  <= '0;
            final_burst <= 1'b0;
            pal_cnt     <= '0;
            pal_done    <= 1'b0;
            eof         <= 1'b0;
        end else begin
            pal_done <= 1'b0;
            eof      <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (raster_en) begin
                        cur_first <= sh_span.first;
                        cur_last  <= sh_cfg.pal_only ?
                                     sh_span.first + ADDR_W'(PAL_BYTES - 1) : sh_span.last;
                        addr      <= sh_span.first;
                        cfg_l     <= sh_cfg;
                        pal_cnt   <= '0;
                        state     <= SQ_ASK;
                    end
                end
                SQ_ASK: begin
                    if (!raster_en) begin
                        state <= SQ_IDLE;
                    end else if (mem_req && mem_ack) begin
                        beats_left  <= blen;
                        addr        <= addr + (ADDR_W'(blen) << WORD_SHIFT);
                        final_burst <= (words_left <= ADDR_W'(bw));
                        state       <= SQ_BEATS;
                    end
                end
                SQ_BEATS: begin
                    if (beat) begin
                        beats_left <= beats_left - LEN_W'(1);
                        if (cfg_l.pal_only)
                            pal_cnt <= pal_cnt + PAL_IDX_W'(1);
                    end
                    if (last_beat) begin
                        if (final_burst && cfg_l.pal_only) begin
                            pal_done <= 1'b1;
                            state    <= SQ_PALOK;
                        end else if (final_burst) begin
                            eof <= 1'b1;
                            if (raster_en) begin
                                cur_first <= sh_span.first;
                                cur_last  <= sh_cfg.pal_only ?
                                             sh_span.first + ADDR_W'(PAL_BYTES - 1) : sh_span.last;
                                addr      <= sh_span.first;
                                cfg_l     <= sh_cfg;
                                pal_cnt   <= '0;
                                state     <= SQ_ASK;
                            end else begin
                                state <= SQ_IDLE;
                            end
                        end else begin
                            state <= raster_en ? SQ_ASK : SQ_IDLE;
                        end
                    end
                end
                SQ_PALOK: begin
                    if (!raster_en)
                        state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R4
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_len != '0) && (mem_len <= burst_words(cfg_l.bcode)));

    // R4
    addr_window_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr >= cur_first) && (mem_addr <= cur_last));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (!raster_en || (mem_req && $stable(mem_addr))));

    // R6
    pal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        pal_done |=> !mem_req);

endmodule

// File: rtl/scanfetch_top.sv
module scanfetch_top
    import scanfetch_pkg::*;
#(
    parameter int FIFO_DEPTH = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 raster_en,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [LEN_W-1:0]     mem_len,
    input  logic                 mem_ack,
    input  logic                 mem_dvalid,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 px_valid,
    output logic [WORD_W-1:0]    px_data,
    input  logic                 px_ready,
    output logic                 pal_we,
    output logic [PAL_IDX_W-1:0] pal_idx,
    output logic [WORD_W-1:0]    pal_data,
    output logic                 pal_done,
    output logic                 eof,
    output logic                 underflow
);

    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    span_t            sh_span;
    fetch_cfg_t       sh_cfg;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_push;
    logic             fifo_flush;
    logic             data_active;
    logic             px_pop;

    assign px_pop   = px_valid && px_ready;
    assign pal_data = mem_rdata;

    scanfetch_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .sh_span   (sh_span),
        .sh_cfg    (sh_cfg)
    );

    scanfetch_seq #(.FIFO_DEPTH(FIFO_DEPTH)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .raster_en   (raster_en),
        .sh_span     (sh_span),
        .sh_cfg      (sh_cfg),
        .fifo_count  (fifo_count),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_len     (mem_len),
        .mem_ack     (mem_ack),
        .mem_dvalid  (mem_dvalid),
        .fifo_push   (fifo_push),
        .fifo_flush  (fifo_flush),
        .pal_we      (pal_we),
        .pal_idx     (pal_idx),
        .pal_done    (pal_done),
        .eof         (eof),
        .data_active (data_active)
    );

    scanfetch_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (fifo_flush),
        .push  (fifo_push),
        .wdata (mem_rdata),
        .pop   (px_pop),
        .rdata (px_data),
        .valid (px_valid),
        .count (fifo_count)
    );

    always_ff @(posedge clk) begin
        if (rst)
            underflow <= 1'b0;
        else
            underflow <= raster_en && data_active && px_ready && !px_valid;
    end

    // R8
    no_req_off_chk: assert property (@(posedge clk) disable iff (rst)
        !raster_en |-> !mem_req);

    // R9
    uf_gate_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |-> $past(raster_en));

endmodule

// File: tb/scanfetch_top_test.sv
module scanfetch_top_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PAL_BASE = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic        raster_en = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_len;
    logic        mem_ack = 1'b0;
    logic        mem_dvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        px_valid;
    logic [31:0] px_data;
    logic        px_ready = 1'b0;
    logic        pal_we;
    logic [2:0]  pal_idx;
    logic [31:0] pal_data;
    logic        pal_done;
    logic        eof;
    logic        underflow;

    int errors = 0;
    int checks = 0;
    int eof_cnt = 0, paldone_cnt = 0, uf_cnt = 0, palwr_cnt = 0, valid_cycles = 0;
    int burst_cnt = 0, beat_total = 0, ack_wait = 0;
    int lenq[$];
    logic [31:0] addrq[$];
    logic [31:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    scanfetch_top uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .raster_en(raster_en), .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_ack(mem_ack), .mem_dvalid(mem_dvalid), .mem_rdata(mem_rdata),
        .px_valid(px_valid), .px_data(px_data), .px_ready(px_ready),
        .pal_we(pal_we), .pal_idx(pal_idx), .pal_data(pal_data),
        .pal_done(pal_done), .eof(eof), .underflow(underflow)
    );

    function automatic logic [31:0] word_at(input logic [31:0] a);
        if (a >= PAL_BASE && a < PAL_BASE + 32)
            return (a == PAL_BASE) ? 32'h0000_4000 : 32'h0;
        return {~a[15:0], a[15:0]};
    endfunction

    function automatic logic [63:0] ctrl_word(input int code, input bit pal, input bit dual, input int thr);
        logic [63:0] w = '0;
        w[2:0]  = 3'(code);
        w[3]    = dual;
        w[4]    = pal;
        w[12:8] = 5'(thr);
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input bit sel, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push_frame(input logic [31:0] first, input logic [31:0] last);
        for (logic [31:0] a = first; a <= last; a += 4)
            expq.push_back(word_at(a));
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Memory model: grants requests, then returns the burst beats.
    initial begin
        forever begin
            @(negedge clk); #1;
            if (mem_req) begin
                logic [31:0] a;
                int n;
                a = mem_addr;
                n = int'(mem_len);
                for (int k = 0; k < ack_wait; k++) begin
                    @(negedge clk); #1;
                    chk(mem_req && (mem_addr == a), "R10", "request held until ack",
                        {mem_req, mem_addr}, {1'b1, a});
                end
                mem_ack = 1'b1;
                burst_cnt++;
                lenq.push_back(n);
                addrq.push_back(a);
                @(negedge clk); #1;
                mem_ack = 1'b0;
                for (int i = 0; i < n; i++) begin
                    mem_dvalid = 1'b1;
                    mem_rdata  = word_at(a + 32'(4 * i));
                    beat_total++;
                    @(negedge clk); #1;
                end
                mem_dvalid = 1'b0;
            end
        end
    end

    // Monitor: pulse counters and scoreboard comparison.
    initial begin
        forever begin
            @(negedge clk); #2;
            if (!rst) begin
                if (eof) eof_cnt++;
                if (pal_done) paldone_cnt++;
                if (underflow) uf_cnt++;
                if (px_valid) valid_cycles++;
                if (pal_we) begin
                    chk(pal_idx == 3'(palwr_cnt), "R6", "palette index", pal_idx, palwr_cnt);
                    chk(pal_data == word_at(PAL_BASE + 32'(4 * palwr_cnt)), "R6", "palette word",
                        pal_data, word_at(PAL_BASE + 32'(4 * palwr_cnt)));
                    palwr_cnt++;
                end
                if (px_valid && px_ready) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R4", "unexpected pixel word", px_data, 0);
                    end else begin
                        logic [31:0] e;
                        e = expq.pop_front();
                        chk(px_data == e, "R4", "pixel word order", px_data, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        int e0, b0, t0, u0, v0, p0;

        // Reset state
        cycles(3);
        chk(!mem_req && !px_valid && !pal_we && !pal_done && !eof && !underflow, "R1",
            "outputs in reset", {mem_req, px_valid, pal_we, pal_done, eof, underflow}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req && !px_valid && !pal_we && !pal_done && !eof && !underflow, "R1",
            "outputs after reset", {mem_req, px_valid, pal_we, pal_done, eof, underflow}, 0);

        // Raster off: no underflow, no request
        px_ready = 1'b1;
        u0 = uf_cnt;
        cycles(10);
        chk(uf_cnt == u0, "R9", "no underflow with raster off", uf_cnt - u0, 0);
        chk(burst_cnt == 0, "R8", "no request with raster off", burst_cnt, 0);

        // Palette load: end address far away must be ignored
        cfg_write(1'b1, {32'h0000_FFFF, PAL_BASE});
        cfg_write(1'b0, ctrl_word(2, 1'b1, 1'b0, 0));
        lenq.delete();
        b0 = burst_cnt; v0 = valid_cycles; p0 = paldone_cnt;
        ack_wait = 2;
        raster_en = 1'b1;
        for (int i = 0; i < 200 && paldone_cnt == p0; i++) @(negedge clk);
        cycles(20);
        ack_wait = 0;
        chk(paldone_cnt == p0 + 1, "R6", "palette done pulses", paldone_cnt - p0, 1);
        chk(palwr_cnt == 8, "R6", "palette words written", palwr_cnt, 8);
        chk(burst_cnt == b0 + 2, "R6", "palette bursts", burst_cnt - b0, 2);
        chk(lenq.size() == 2 && lenq[0] == 4 && lenq[1] == 4, "R2", "code 2 gives 4 words",
            lenq.size() > 0 ? lenq[0] : 0, 4);
        chk(valid_cycles == v0, "R6", "no palette word in FIFO", valid_cycles - v0, 0);
        raster_en = 1'b0;
        cycles(5);

        // Frame of 70 words, code 7 clamps to 16, second-buffer bit set
        cfg_write(1'b1, {32'h0000_1117, 32'h0000_1000});
        cfg_write(1'b0, ctrl_word(7, 1'b0, 1'b1, 16));
        lenq.delete(); addrq.delete();
        push_frame(32'h1000, 32'h1117);
        push_frame(32'h1000, 32'h1117);
        e0 = eof_cnt; u0 = uf_cnt;
        raster_en = 1'b1;
        for (int i = 0; i < 2000 && eof_cnt == e0; i++) @(negedge clk);
        cycles(5);
        chk(eof_cnt == e0 + 1, "R7", "one eof per frame", eof_cnt - e0, 1);
        chk(lenq.size() >= 6, "R7", "next frame started", lenq.size(), 6);
        if (lenq.size() >= 6) begin
            chk(lenq[0] == 16, "R2", "code 7 clamps to 16", lenq[0], 16);
            chk(lenq[4] == 6, "R4", "final burst cut to remainder", lenq[4], 6);
            chk(addrq[4] == 32'h1100, "R4", "final burst address", addrq[4], 32'h1100);
            chk(addrq[5] == 32'h1000, "R7", "restart at start address", addrq[5], 32'h1000);
        end
        chk(uf_cnt > u0, "R9", "underflow on empty FIFO", uf_cnt - u0, 1);
        raster_en = 1'b0;
        cycles(40);
        expq.delete();

        // Address pair rewritten mid-frame
        cfg_write(1'b1, {32'h0000_209F, 32'h0000_2000});
        cfg_write(1'b0, ctrl_word(3, 1'b0, 1'b0, 16));
        lenq.delete(); addrq.delete();
        push_frame(32'h2000, 32'h209F);
        e0 = eof_cnt; b0 = burst_cnt;
        raster_en = 1'b1;
        while (burst_cnt < b0 + 2) @(negedge clk);
        cfg_write(1'b1, {32'h0000_305F, 32'h0000_3000});
        push_frame(32'h3000, 32'h305F);
        push_frame(32'h3000, 32'h305F);
        for (int i = 0; i < 2000 && eof_cnt < e0 + 2; i++) @(negedge clk);
        cycles(3);
        raster_en = 1'b0;
        cycles(40);
        expq.delete();
        chk(eof_cnt == e0 + 2, "R7", "two frames completed", eof_cnt - e0, 2);
        chk(addrq.size() >= 9, "R3", "burst count over two frames", addrq.size(), 9);
        if (addrq.size() >= 9) begin
            chk(addrq[4] == 32'h2080, "R3", "old pair kept for running frame", addrq[4], 32'h2080);
            chk(addrq[5] == 32'h3000, "R3", "new pair from next frame", addrq[5], 32'h3000);
            chk(addrq[8] == 32'h3000, "R7", "wrap to new start address", addrq[8], 32'h3000);
        end

        // Refill threshold with a stalled raster
        px_ready = 1'b0;
        cfg_write(1'b1, {32'h0000_50FF, 32'h0000_5000});
        cfg_write(1'b0, ctrl_word(2, 1'b0, 1'b0, 5));
        t0 = beat_total;
        raster_en = 1'b1;
        cycles(60);
        chk(beat_total - t0 == 8, "R5", "threshold 5 fill level", beat_total - t0, 8);
        raster_en = 1'b0;
        cycles(10);
        chk(!px_valid, "R8", "FIFO emptied when idle", px_valid, 0);
        cfg_write(1'b0, ctrl_word(2, 1'b0, 1'b0, 8));
        t0 = beat_total;
        raster_en = 1'b1;
        cycles(60);
        chk(beat_total - t0 == 12, "R5", "threshold 8 fill level", beat_total - t0, 12);
        raster_en = 1'b0;
        cycles(10);
        expq.delete();
        px_ready = 1'b1;

        // Raster disabled while a burst is in flight
        cfg_write(1'b1, {32'h0000_60FF, 32'h0000_6000});
        cfg_write(1'b0, ctrl_word(4, 1'b0, 1'b0, 16));
        push_frame(32'h6000, 32'h60FF);
        b0 = burst_cnt; t0 = beat_total;
        raster_en = 1'b1;
        while (burst_cnt < b0 + 2) @(negedge clk);
        @(negedge clk); #3;
        raster_en = 1'b0;
        cycles(40);
        chk(beat_total - t0 == 32, "R8", "granted burst completes", beat_total - t0, 32);
        chk(burst_cnt == b0 + 2, "R8", "no request after disable", burst_cnt - b0, 2);
        chk(!mem_req, "R8", "request low while off", mem_req, 0);
        chk(!px_valid, "R8", "FIFO emptied after stop", px_valid, 0);
        expq.delete();

        finish_run();
    end

endmodule